// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This block is a watchdog built around a 64-bit up-counter and a 64-bit timeout period, each reached through two 32-bit halves on a simple word-wide register bus. Software configures the counter, the period, a counting mode and two half-reset releases while the watchdog is still idle. It then arms the watchdog with an ordered pair of 16-bit key writes.

Once armed, the configuration is frozen. Software keeps the system alive by repeating the same key pair, which zeroes the counter. If the count ever matches the period while the watchdog is running, the block latches a timeout flag and asks for a system reset with a one-cycle pulse.

Register reads are combinational from the address. A write is taken on the rising clock edge where `bus_wr` is high.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter and period read zero, the mode, global and watchdog control registers read zero, `rst_req` is low, and offset 0x00 returns the `IDENT` parameter.
- R2: Byte offsets: 0x10/0x14 hold the counter low/high halves, 0x18/0x1C hold the period low/high halves, 0x20 is mode control, 0x24 is global control and 0x28 is watchdog control. Offset 0x04 and unmapped offsets read zero. Counter reads return the live count.
- R3: The counter is forced to zero unless global control bits 0 and 1 are both set. Otherwise it adds one per clock whenever mode control bits 7:6 are non-zero. A counter-half write takes precedence over counting for that cycle.
- R4: The count is a true 64-bit value: a carry out of the low half increments the high half.
- R5: Writing watchdog control with key 0xA5C6 in bits 31:16 and bit 14 set moves the block from idle to armed. A following write of key 0xDA7E with bit 14 set moves it from armed to running. Any key other than the one expected for the current state changes nothing.
- R6: From armed onward, writes to the counter halves, period halves, mode control and global control are ignored. Watchdog control accepts only its key field.
- R7: While running, key 0xA5C6 enters a service state. A following key 0xDA7E clears the counter to zero and returns to running.
- R8: In the running or service state, a count equal to the period sets the timeout flag (watchdog control bit 15), which stays set until reset. The same event drives `rst_req` high for exactly one cycle, and only the first such event does so.
- R9: Once armed, software cannot return the watchdog to idle. Watchdog control bit 14 reads one from then on.
- R10: No timeout occurs in the idle or armed states, even when the count passes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request on timeout |

## Verification
Random trials pick a period, a counting mode and a series of service gaps that always stay short of the period. The live counter reads must match the elapsed cycles, and the trial must end with a reset pulse exactly one cycle after the count reaches the period. This separates a correct clear-on-service from a late or missing clear, and a correct equality compare from an off-by-one. Directed sequences cover the remaining cases:
- wrong keys and keys without the enable bit, with the effect told apart at the ports by period writability and by whether a lone 0xDA7E clears the count;
- a count passing the period while armed;
- locked writes and a software disable attempt;
- held-reset counting;
- the carry across the two halves.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] IDENT   = 32'h4B57_0001,
  parameter logic [15:0] KEY_ARM = 16'hA5C6,
  parameter logic [15:0] KEY_GO  = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] OFS_ID   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CLO  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_CHI  = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_PLO  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_PHI  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_GLB  = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_WCTL = ADDR_W'('h28);

  typedef enum logic [1:0] {WD_IDLE, WD_ARMED, WD_RUN, WD_SVC} wd_state_t;

  wd_state_t   st;
  logic [63:0] cnt, prd;
  logic [1:0]  mode;
  logic [3:0]  glb;
  logic        flag;

  wire        unlocked = (st == WD_IDLE);
  wire        held     = !(glb[0] && glb[1]);
  wire [15:0] key      = bus_wdata[31:16];
  wire        en_bit   = bus_wdata[14];
  wire        key_wr   = bus_wr && (bus_addr == OFS_WCTL);
  wire        cfg_wr   = bus_wr && unlocked;
  wire        svc_clr  = key_wr && (st == WD_SVC) && (key == KEY_GO);
  wire        live     = (st == WD_RUN) || (st == WD_SVC);
  wire        hit      = live && (cnt == prd) && !flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= WD_IDLE;
    else if (key_wr) begin
      case (st)
        WD_IDLE:  if (key == KEY_ARM && en_bit) st <= WD_ARMED;
        WD_ARMED: if (key == KEY_GO && en_bit)  st <= WD_RUN;
        WD_RUN:   if (key == KEY_ARM)           st <= WD_SVC;
        WD_SVC:   if (key == KEY_GO)            st <= WD_RUN;
        default:                                st <= WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd  <= '0;
      mode <= '0;
      glb  <= '0;
    end else if (cfg_wr) begin
      if (bus_addr == OFS_PLO)  prd[31:0]  <= bus_wdata;
      if (bus_addr == OFS_PHI)  prd[63:32] <= bus_wdata;
      if (bus_addr == OFS_MODE) mode       <= bus_wdata[7:6];
      if (bus_addr == OFS_GLB)  glb        <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt         <= '0;
    else if (held || svc_clr)                   cnt         <= '0;
    else if (cfg_wr && bus_addr == OFS_CLO)     cnt[31:0]   <= bus_wdata;
    else if (cfg_wr && bus_addr == OFS_CHI)     cnt[63:32]  <= bus_wdata;
    else if (mode != 2'd0)                      cnt         <= cnt + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      flag    <= flag | hit;
      rst_req <= hit;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_ID:   bus_rdata = IDENT;
      OFS_CLO:  bus_rdata = cnt[31:0];
      OFS_CHI:  bus_rdata = cnt[63:32];
      OFS_PLO:  bus_rdata = prd[31:0];
      OFS_PHI:  bus_rdata = prd[63:32];
      OFS_MODE: bus_rdata = {24'd0, mode, 6'd0};
      OFS_GLB:  bus_rdata = {28'd0, glb};
      OFS_WCTL: bus_rdata = {16'd0, flag, !unlocked, 14'd0};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assert_lock_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != WD_IDLE) |=> $stable(prd));
  assert_lock_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != WD_IDLE) |=> ($stable(mode) && $stable(glb)));
  assert_svc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_SVC && key_wr && key == KEY_GO) |=> (cnt == 64'd0 && st == WD_RUN));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
  assert_pulse_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_pulse_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (flag && !$past(flag)));
  assert_no_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != WD_IDLE) |=> (st != WD_IDLE));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_IDLE || st == WD_ARMED) |=> !rst_req);

endmodule

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
  localparam logic [31:0] IDENT = 32'h4B57_0001;
  localparam logic [31:0] ARM_EN = 32'hA5C6_4000;
  localparam logic [31:0] GO_EN  = 32'hDA7E_4000;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rst_req;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  keyed_wdt uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  function automatic logic [31:0] wctl_exp(input bit flg, input bit en);
    return {16'd0, flg, en, 14'd0};
  endfunction
  function automatic int pulse_at(input int period);
    return period + 1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch_pulses(input int span, output int first, output int total);
    first = -1; total = 0;
    for (int k = 1; k <= span; k++) begin
      @(negedge clk); #1;
      if (rst_req) begin
        total++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic run_all();
    logic [31:0] v, v2, hi;
    int first, total;

    do_reset();
    rd(8'h00, v); chk("R1 ident", v, IDENT);
    rd(8'h10, v); chk("R1 count low", v, 0);
    rd(8'h1C, v); chk("R1 period high", v, 0);
    rd(8'h20, v); chk("R1 mode", v, 0);
    rd(8'h24, v); chk("R1 global", v, 0);
    rd(8'h28, v); chk("R1 wctl", v, 0);
    chk("R1 rst_req", rst_req, 0);
    rd(8'h04, v); chk("R2 unused offset", v, 0);

    // R3 held counting
    wr(8'h20, 32'h80);
    wait_n(5); rd(8'h10, v); chk("R3 held at zero", v, 0);
    wr(8'h24, 32'h3);
    wait_n(7); rd(8'h10, v); chk("R3 counts when released", v, 7);
    wr(8'h24, 32'h1);
    wait_n(2); rd(8'h10, v); chk("R3 held again", v, 0);

    // R4 carry
    wr(8'h24, 32'hB); wr(8'h20, 32'h0);
    wr(8'h10, 32'hFFFF_FFFE); wr(8'h14, 32'h5);
    wr(8'h20, 32'h80);
    rd(8'h10, v); chk("R4 written low", v, 32'hFFFF_FFFE);
    wait_n(2);
    rd(8'h10, v); rd(8'h14, hi);
    chk("R4 carry low", v, 0); chk("R4 carry high", hi, 6);

    // R5 R6 R10 R9 directed sequence
    do_reset();
    wr(8'h24, 32'hB); wr(8'h18, 32'd4); wr(8'h20, 32'h80);
    wr(8'h28, 32'h1234_4000);
    rd(8'h28, v); chk("R5 wrong key idle", v, wctl_exp(0, 0));
    wr(8'h28, 32'hA5C6_0000);
    rd(8'h28, v); chk("R5 key without enable", v, wctl_exp(0, 0));
    wr(8'h18, 32'd6);
    rd(8'h18, v); chk("R6 period writable when idle", v, 6);
    wr(8'h28, ARM_EN);
    rd(8'h28, v); chk("R5 armed enable bit", v, wctl_exp(0, 1));
    wr(8'h18, 32'd9);
    rd(8'h18, v); chk("R6 period locked", v, 6);
    watch_pulses(10, first, total);
    chk("R10 no timeout while armed", total, 0);
    wr(8'h28, ARM_EN);
    wr(8'h28, GO_EN);
    rd(8'h10, v); wr(8'h28, GO_EN); rd(8'h10, v2);
    chk("R5 lone second key does not clear", v2, v + 1);
    wr(8'h24, 32'h0);
    rd(8'h10, v); wait_n(3); rd(8'h10, v2);
    chk("R6 global locked", v2, v + 3);
    wr(8'h20, 32'h0);
    rd(8'h10, v); wait_n(3); rd(8'h10, v2);
    chk("R6 mode locked", v2, v + 3);
    rd(8'h10, v); wr(8'h10, 32'h0); rd(8'h10, v2);
    chk("R6 counter locked", v2, v + 1);
    wr(8'h28, 32'h0);
    rd(8'h28, v); chk("R9 cannot disable", v, wctl_exp(0, 1));
    wr(8'h28, 32'hA5C6_0000); wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, v); chk("R7 service clears", v, 0);
    watch_pulses(pulse_at(6) + 4, first, total);
    chk("R8 pulse cycle", first, pulse_at(6));
    chk("R8 single pulse", total, 1);
    rd(8'h28, v); chk("R8 flag set", v, wctl_exp(1, 1));

    // random trials
    void'($urandom(32'd4242));
    for (int t = 0; t < 12; t++) begin
      int p, nsvc, cur;
      p = 10 + int'($urandom % 50);
      nsvc = 1 + int'($urandom % 4);
      do_reset();
      wr(8'h24, 32'hB);
      wr(8'h18, p); wr(8'h1C, 32'h0);
      wr(8'h20, ($urandom % 2) ? 32'h40 : 32'h80);
      wr(8'h28, ARM_EN); wr(8'h28, GO_EN);
      cur = 2;
      for (int s = 0; s < nsvc; s++) begin
        int g;
        g = int'($urandom % (p - 5));
        wait_n(g);
        rd(8'h10, v); chk("R2 live count", v, cur + g);
        wr(8'h28, {16'hA5C6, 16'h0}); wr(8'h28, {16'hDA7E, 16'h0});
        rd(8'h10, v); chk("R7 random service clears", v, 0);
        rd(8'h28, v); chk("R8 no flag before period", v, wctl_exp(0, 1));
        cur = 0;
      end
      watch_pulses(pulse_at(p) + 4, first, total);
      chk("R8 random pulse cycle", first, pulse_at(p));
      chk("R8 random single pulse", total, 1);
      wr(8'h28, ARM_EN); wr(8'h28, GO_EN);
      watch_pulses(p + 5, first, total);
      chk("R8 no second pulse", total, 0);
      rd(8'h28, v); chk("R8 flag sticky", v, wctl_exp(1, 1));
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule